// File: doc/BRIEF.md
# Leading-One Top-K Attention Score Predictor

During each decode step this block estimates how strongly the current query matches every key already held in the key-value cache. It then keeps only the best-matching tokens, so that exact attention fetches just those entries. A full multiply per element is not used. For each element, the block finds the position of the highest set bit of the magnitude of each 8-bit operand. It adds the two positions, which acts as a multiplication in the log domain, and the result gives a power-of-two magnitude. The sign of that term comes from the sign bits of the two operands. The terms are summed across the vector into a signed estimate.

Software or a controller pulses `start` with the query and the wanted count K. It then streams cached keys, one per accepted cycle, each tagged with its token index, and marks the final key. A sorted register list keeps the K highest estimates as the keys arrive. When the final key has been taken, `done` rises and the list holds the token indices to fetch, ranked from the highest estimate down.

Top module: `lop_topk`

## Requirements
- R1: After reset `out_valid` is all zero and `done` is low.
- R2: A cycle with `start` high latches `q_vec` and `k_num`, empties the list and lowers `done`; from the next cycle `out_valid` is zero. If `start` and `key_valid` are both high, `start` wins.
- R3: The estimate for a key is the sum over all DIM elements of one term per element. An element where either operand is zero contributes nothing. Otherwise the term has magnitude 2^(a+b), where a and b are the bit indices of the highest set bit of each operand's absolute value (|-128| = 128 gives index 7). The term is negative when the two sign bits differ. The sum is held as a 24-bit signed value.
- R4: The list holds the keys with the highest estimates, sorted in descending order, with slot 0 the highest. Slot i's token index appears on `out_idx[i*IDXW +: IDXW]` and its occupancy on `out_valid[i]`.
- R5: A new key displaces the lowest kept entry only when its estimate is strictly greater. Among equal estimates, the key that arrived earlier ranks higher and is the one kept.
- R6: When fewer than K keys have arrived, all of them are listed, and `out_valid` is a contiguous mask from bit 0 whose popcount equals the number of keys received.
- R7: While `key_valid` is low, `key_vec`, `key_idx` and `key_last` have no effect on the list or on `done`.
- R8: `done` is high from the cycle after the clock edge that accepts a key with `key_last` set, and it stays high until the next `start`.
- R9: The effective K is `k_num`, saturated to KMAX. The number of valid slots never exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new step: latch query and K, clear list |
| k_num | input | $clog2(KMAX+1) | Number of tokens to keep |
| q_vec | input | DIM*8 | Query vector, signed 8-bit elements, element d at [d*8 +: 8] |
| key_valid | input | 1 | A key is presented this cycle |
| key_vec | input | DIM*8 | Key vector, same layout as the query |
| key_idx | input | IDXW | Token index of the presented key |
| key_last | input | 1 | Presented key is the final one of the step |
| out_idx | output | KMAX*IDXW | Ranked token indices, slot 0 highest |
| out_valid | output | KMAX | Slot occupancy mask |
| done | output | 1 | Selection for the step is complete |

## Verification
The bench aims at equal estimates. A list that used greater-or-equal would let later tokens push out earlier ones, and the ranking would come out reversed. It streams fewer keys than K and sets K above KMAX. Both cases expose a mask that is not contiguous or a count that overflows the list. One hand-built step uses zero operands, -128 and mixed signs, which catches leading-one or sign errors in the estimator. Another step places very high-scoring garbage on the key bus while `key_valid` is low, so a design that samples the bus without qualification would list that garbage index.

// File: rtl/lop_topk.sv
module lop_topk #(
  parameter int DIM  = 8,
  parameter int IDXW = 16,
  parameter int KMAX = 16,
  parameter int SW   = 24,
  localparam int KW  = $clog2(KMAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [KW-1:0]        k_num,
  input  logic [DIM*8-1:0]     q_vec,
  input  logic                 key_valid,
  input  logic [DIM*8-1:0]     key_vec,
  input  logic [IDXW-1:0]      key_idx,
  input  logic                 key_last,
  output logic [KMAX*IDXW-1:0] out_idx,
  output logic [KMAX-1:0]      out_valid,
  output logic                 done
);

  logic [DIM*8-1:0]      q_r;
  logic [KW-1:0]         k_r;
  logic signed [SW-1:0]  s_r [KMAX];
  logic [IDXW-1:0]       id_r [KMAX];
  logic [KMAX-1:0]       v_r;
  logic signed [SW-1:0]  s_n [KMAX];
  logic [IDXW-1:0]       id_n [KMAX];
  logic [KMAX-1:0]       v_n;
  logic [KMAX-1:0]       gt;
  logic signed [SW-1:0]  score;

  function automatic logic [2:0] lead1(input logic [7:0] v);
    logic [7:0] mag;
    logic [2:0] r;
    mag = v[7] ? (~v + 8'd1) : v;
    r = '0;
    for (int b = 0; b < 8; b++)
      if (mag[b]) r = 3'(b);
    return r;
  endfunction

  always_comb begin
    score = '0;
    for (int d = 0; d < DIM; d++) begin
      logic [7:0] qe, ke;
      logic [3:0] sh;
      logic signed [SW-1:0] term;
      qe = q_r[d*8 +: 8];
      ke = key_vec[d*8 +: 8];
      sh = {1'b0, lead1(qe)} + {1'b0, lead1(ke)};
      term = SW'(1) <<< sh;
      if (qe != 8'd0 && ke != 8'd0)
        score = (qe[7] ^ ke[7]) ? score - term : score + term;
    end
  end

  always_comb begin
    for (int i = 0; i < KMAX; i++)
      gt[i] = key_valid && (i < int'(k_r)) && (!v_r[i] || score > s_r[i]);
    for (int i = 0; i < KMAX; i++) begin
      int p;
      logic up;
      p  = (i == 0) ? 0 : i - 1;
      up = (i == 0) ? 1'b0 : gt[p];
      s_n[i]  = s_r[i];
      id_n[i] = id_r[i];
      v_n[i]  = v_r[i];
      if (gt[i] && !up) begin
        s_n[i]  = score;
        id_n[i] = key_idx;
        v_n[i]  = 1'b1;
      end else if (gt[i] && up) begin
        s_n[i]  = s_r[p];
        id_n[i] = id_r[p];
        v_n[i]  = v_r[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r  <= '0;
      k_r  <= '0;
      v_r  <= '0;
      done <= 1'b0;
      for (int i = 0; i < KMAX; i++) begin
        s_r[i]  <= '0;
        id_r[i] <= '0;
      end
    end else if (start) begin
      q_r  <= q_vec;
      k_r  <= (int'(k_num) > KMAX) ? KW'(KMAX) : k_num;
      v_r  <= '0;
      done <= 1'b0;
    end else begin
      s_r  <= s_n;
      id_r <= id_n;
      v_r  <= v_n;
      if (key_valid && key_last) done <= 1'b1;
    end
  end

  assign out_valid = v_r;
  always_comb
    for (int i = 0; i < KMAX; i++) out_idx[i*IDXW +: IDXW] = id_r[i];

  a_r1_reset_empty: assert property (@(posedge clk) !rst_n |=> (out_valid == '0 && !done));
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n) start |=> (out_valid == '0 && !done));
  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(key_valid && key_last && !start));
  a_r9_count_le_k: assert property (@(posedge clk) disable iff (!rst_n) $countones(out_valid) <= int'(k_r));

  for (genvar i = 0; i < KMAX - 1; i++) begin : g_chk
    a_r6_prefix: assert property (@(posedge clk) disable iff (!rst_n) v_r[i+1] |-> v_r[i]);
    a_r4_sorted: assert property (@(posedge clk) disable iff (!rst_n) v_r[i+1] |-> (s_r[i] >= s_r[i+1]));
  end

endmodule

// File: tb/lop_topk_tb_top.sv
module lop_topk_tb_top;
  localparam int DIM = 8, IDXW = 16, KMAX = 16, KW = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [KW-1:0] k_num = '0;
  logic [DIM*8-1:0] q_vec = '0, key_vec = '0;
  logic key_valid = 1'b0, key_last = 1'b0;
  logic [IDXW-1:0] key_idx = '0;
  logic [KMAX*IDXW-1:0] out_idx;
  logic [KMAX-1:0] out_valid;
  logic done;

  always #4 clk = ~clk;

  lop_topk #(.DIM(DIM), .IDXW(IDXW), .KMAX(KMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .k_num(k_num), .q_vec(q_vec),
    .key_valid(key_valid), .key_vec(key_vec), .key_idx(key_idx), .key_last(key_last),
    .out_idx(out_idx), .out_valid(out_valid), .done(done));

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [KMAX*IDXW-1:0] exp_idx_q[$];
  logic [KMAX-1:0] exp_mask_q[$];
  string exp_tag_q[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lpos(input int m);
    int p = 0;
    while (m > 1) begin m = m >> 1; p++; end
    return p;
  endfunction

  function automatic int est(input logic [DIM*8-1:0] a, input logic [DIM*8-1:0] b);
    int s = 0;
    for (int d = 0; d < DIM; d++) begin
      int ai, bi, t;
      ai = $signed(a[d*8 +: 8]);
      bi = $signed(b[d*8 +: 8]);
      if (ai != 0 && bi != 0) begin
        t = 1 << (lpos(ai < 0 ? -ai : ai) + lpos(bi < 0 ? -bi : bi));
        if ((ai < 0) != (bi < 0)) s -= t; else s += t;
      end
    end
    return s;
  endfunction

  // mode 0 random, 1 identical keys, 2 tied keys with garbage gaps, 3 hand-built
  task automatic run_batch(input int k, input int n, input int mode, input int base, input string tag);
    logic [DIM*8-1:0] keys[40];
    logic [DIM*8-1:0] junk;
    int sc[40];
    bit used[40];
    int keff;
    logic [KMAX*IDXW-1:0] ei;
    logic [KMAX-1:0] em;
    for (int j = 0; j < n; j++) begin
      used[j] = 0;
      for (int d = 0; d < DIM; d++) begin
        case (mode)
          0: keys[j][d*8 +: 8] = 8'($urandom);
          1: keys[j][d*8 +: 8] = q_vec[d*8 +: 8];
          2: keys[j][d*8 +: 8] = 8'(j % 3 + 1);
          default: keys[j][d*8 +: 8] = 8'd0;
        endcase
      end
      if (mode == 3) begin
        case (j)
          1: keys[j] = {DIM{8'hFF}};
          2: keys[j][0 +: 8] = 8'h80;
          3: keys[j][8 +: 8] = 8'h40;
          4: keys[j][16 +: 8] = 8'h7F;
          5: keys[j] = {{(DIM-1){8'h00}}, 8'hC0};
          default: ;
        endcase
      end
      sc[j] = est(q_vec, keys[j]);
    end
    for (int d = 0; d < DIM; d++) junk[d*8 +: 8] = q_vec[d*8+7] ? 8'h80 : 8'h7F;
    keff = (k > KMAX) ? KMAX : k;
    ei = '0; em = '0;
    for (int r = 0; r < keff && r < n; r++) begin
      int best = -1;
      for (int j = 0; j < n; j++)
        if (!used[j] && (best < 0 || sc[j] > sc[best])) best = j;
      used[best] = 1;
      ei[r*IDXW +: IDXW] = IDXW'(base + best);
      em[r] = 1'b1;
    end
    exp_idx_q.push_back(ei);
    exp_mask_q.push_back(em);
    exp_tag_q.push_back(tag);

    @(negedge clk);
    start = 1'b1; k_num = KW'(k);
    @(negedge clk);
    start = 1'b0;
    check(out_valid == '0 && !done, "R2", {out_valid, done}, 0);
    for (int j = 0; j < n; j++) begin
      if (mode == 2 && j % 2 == 1) begin
        key_valid = 1'b0; key_vec = junk; key_idx = 16'hFFFF; key_last = 1'b1;
        @(negedge clk);
      end
      key_valid = 1'b1; key_vec = keys[j]; key_idx = IDXW'(base + j); key_last = (j == n - 1);
      if (j == n - 1) check(!done, "R8", done, 0);
      @(negedge clk);
    end
    key_valid = 1'b0; key_last = 1'b0;
    check(done, "R8", done, 1);
    @(negedge clk);
    @(negedge clk);
    check(done, "R8", done, 1);
  endtask

  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n && done && !prev_done) begin
      if (exp_idx_q.size() == 0) begin
        check(0, "R8", 1, 0);
      end else begin
        logic [KMAX*IDXW-1:0] ei;
        logic [KMAX-1:0] em;
        string tg;
        ei = exp_idx_q.pop_front();
        em = exp_mask_q.pop_front();
        tg = exp_tag_q.pop_front();
        check(out_valid == em, {tg, "/R6 mask"}, out_valid, em);
        for (int i = 0; i < KMAX; i++)
          if (em[i])
            check(out_idx[i*IDXW +: IDXW] == ei[i*IDXW +: IDXW], {tg, "/R4 slot"},
                  out_idx[i*IDXW +: IDXW], ei[i*IDXW +: IDXW]);
      end
    end
    prev_done = done;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == '0 && !done, "R1", {out_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < DIM; d++) q_vec[d*8 +: 8] = 8'($urandom);
    run_batch(4, 12, 0, 10, "R4 random");
    run_batch(16, 5, 0, 40, "R6 fewer than K");
    run_batch(2, 6, 1, 100, "R5 all tied");
    run_batch(5, 11, 2, 200, "R7 gaps with junk, R5 ties");
    run_batch(20, 20, 0, 300, "R9 K saturates");
    run_batch(1, 9, 0, 400, "R4 K one");
    q_vec = {DIM{8'h01}};
    run_batch(4, 7, 3, 500, "R3 zero, -128, signs");
    q_vec = {DIM{8'h80}};
    run_batch(3, 7, 3, 600, "R3 negative query");
    q_vec = '0;
    run_batch(3, 6, 0, 700, "R3 zero query, R5");
    repeat (3) @(negedge clk);
    check(exp_idx_q.size() == 0, "R8 all results seen", exp_idx_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule